// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Transceiver

This block pairs a serial transmitter with a serial receiver. Both share one frame format held in a small configuration register: a parity mode (none, forced zero, odd or even), a 7- or 8-bit character and, for the transmitter only, one or two stop bits. An external baud tick strobes sixteen times per bit period and sets all bit timing. The transmitter takes a character through a load/ready handshake. The receiver presents each character on a parallel output with a held valid flag, together with sticky parity, framing and overrun flags and a one-cycle error interrupt.

Each direction runs only while the block-level power enable and its own direction enable are both high. Each direction enable passes through a two-flop resynchroniser and a hold counter, so a direction stays in reset for at least two clocks after it is disabled. The format may be written only while both direction enables are low.

The transmitter state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP:
- TX_IDLE to TX_START on a load while running.
- TX_START to TX_DATA after one bit period.
- TX_DATA to TX_PAR, or to TX_STOP when there is no parity, after the last data bit.
- TX_PAR to TX_STOP after one bit period.
- TX_STOP to TX_IDLE after one or two stop periods.

The receiver state machine has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP:
- RX_IDLE to RX_START on a low line.
- RX_START back to RX_IDLE if the line is high again at the mid-start sample; otherwise RX_START to RX_DATA.
- RX_DATA to RX_PAR, or to RX_STOP when there is no parity, after the last data sample.
- RX_PAR to RX_STOP.
- RX_STOP to RX_IDLE after the single stop sample, which completes the character.

Either machine is forced to its idle state whenever its direction is not running.

Top module: `uart_xcvr`

## Requirements
- R1: A transmitted frame is a low start bit, then the data bits LSB first (7 when cfg_len8=0, 8 when cfg_len8=1, upper bit of tx_data ignored in 7-bit mode), then the optional parity bit, then high stop bits; each bit lasts 16 baud ticks and the idle line is high.
- R2: cfg_parity selects the transmit parity bit: 00 none sent, 01 a 0 bit, 10 odd (data ones plus parity bit odd), 11 even (that count even).
- R3: cfg_stop2=0 sends one stop bit and cfg_stop2=1 sends two; tx_ready returns high at the end of the last stop bit.
- R4: The receiver samples each bit at its midpoint. It assembles the data LSB first; 7-bit characters appear in rx_data[6:0] with rx_data[7]=0. rx_valid stays high until rx_ack.
- R5: In modes 10 and 11 the receiver checks the parity slot and sets err_parity on mismatch. In mode 01 it consumes the slot but never flags it. In mode 00 it expects no slot.
- R6: The receiver checks exactly one stop bit, whatever cfg_stop2 is; a low stop sample sets err_frame, and a frame followed at once by the next start bit is accepted.
- R7: A character that completes while rx_valid is still high sets err_overrun and replaces rx_data.
- R8: Each completed character that sets any error flag gives one err_irq pulse of exactly one cycle; the flags stay set until stat_rd.
- R9: A low level that is high again at the mid-start sample is not a start bit, and no character results.
- R10: If the receiver becomes enabled while rxd is already low, that low is taken as the start bit.
- R11: While pwr_en or a direction enable is low, that direction is idle: txd is high and tx_ready low, or rx_valid and all error flags are clear.
- R12: Once a direction's enable is cleared, that direction stays in reset for at least two clocks, so even a one-cycle enable drop aborts a frame in progress.
- R13: A cfg_we while tx_en or rx_en is high leaves the frame format unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Block power enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_we | input | 1 | Frame format write strobe |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| cfg_len8 | input | 1 | 1 for 8 data bits, 0 for 7 |
| cfg_stop2 | input | 1 | 1 for two transmit stop bits |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Starts a frame when tx_ready is high |
| tx_ready | output | 1 | Transmitter idle and running |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | Unread character present |
| rx_ack | input | 1 | Takes the received character |
| stat_rd | input | 1 | Status read, clears error flags |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| err_irq | output | 1 | One-cycle error interrupt |

## Verification
A wrong transmit state or bit counter shows on txd within one bit period, as a misplaced level at a bit midpoint, and on tx_ready as a frame length that is off by whole bit periods. A receiver that counts slots wrongly delivers a shifted rx_data or a spurious framing or parity flag at the end of the same character. A broken enable path shows within about five clocks, because tx_ready and txd fail to return to idle after a short enable drop.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_t;

    typedef struct packed {
        par_mode_t par;
        logic      len8;
        logic      stop2;
    } frame_cfg_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

    // parity bit that the given mode attaches to a character
    function automatic logic par_bit(input par_mode_t m, input logic [7:0] d);
        unique case (m)
            PAR_ODD:  return ~^d;
            PAR_EVEN: return ^d;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/uart_en_gate.sv
module uart_en_gate #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic en,
    output logic run
);
    localparam int HW = $clog2(HOLD + 1);

    logic [1:0]    sync_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hold_q <= HW'(HOLD);
        end else begin
            sync_q <= {sync_q[0], en};
            if (!(pwr && sync_q[1]))
                hold_q <= HW'(HOLD);
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

    assign run = pwr && sync_q[1] && (hold_q == '0);

    assert_hold_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |=> !run);
    assert_hold_second_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |=> ##1 !run);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_fmt_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic [DW-1:0] din,
    input  logic          load,
    output logic          ready,
    output logic          txd
);
    localparam int CW = $clog2(OS);
    localparam int BW = $clog2(DW + 1);

    tx_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          par_q, stop_q;
    logic [DW-1:0] mask, dmask;
    logic [BW-1:0] nbits;
    logic          bit_end;

    assign mask    = cfg.len8 ? '1 : {1'b0, {(DW-1){1'b1}}};
    assign dmask   = din & mask;
    assign nbits   = cfg.len8 ? BW'(DW) : BW'(DW - 1);
    assign bit_end = tick && (cnt_q == CW'(OS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (load) st_d = TX_START;
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == nbits - 1'b1)
                          st_d = (cfg.par == PAR_NONE) ? TX_STOP : TX_PAR;
            TX_PAR:   if (bit_end) st_d = TX_STOP;
            TX_STOP:  if (bit_end && (stop_q || !cfg.stop2)) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= TX_IDLE;
        else if (!run) st_q <= TX_IDLE;
        else          st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; bit_q <= '0; sh_q <= '0; par_q <= 1'b0; stop_q <= 1'b0;
        end else if (!run || st_q == TX_IDLE) begin
            cnt_q <= '0; bit_q <= '0; stop_q <= 1'b0;
            if (run && load) begin
                sh_q  <= dmask;
                par_q <= par_bit(cfg.par, dmask);
            end
        end else if (tick) begin
            if (bit_end) begin
                cnt_q <= '0;
                if (st_q == TX_DATA) begin
                    sh_q  <= sh_q >> 1;
                    bit_q <= bit_q + 1'b1;
                end
                if (st_q == TX_STOP) stop_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
        if (!run) txd = 1'b1;
    end

    assign ready = run && (st_q == TX_IDLE);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready) |=> (!txd || !run));
    assert_ready_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_fmt_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    input  logic          ack,
    input  logic          rd,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic          perr,
    output logic          ferr,
    output logic          oerr,
    output logic          irq
);
    localparam int CW = $clog2(OS);
    localparam int BW = $clog2(DW + 1);

    rx_state_t     st_q, st_d;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q, word;
    logic          par_q;
    logic [BW-1:0] nbits;
    logic          bit_end, mid_end, done;
    logic          perr_set, ferr_set, oerr_set;

    assign rx_s    = sync_q[1];
    assign nbits   = cfg.len8 ? BW'(DW) : BW'(DW - 1);
    assign bit_end = tick && (cnt_q == CW'(OS - 1));
    assign mid_end = tick && (cnt_q == CW'(OS / 2 - 1));
    assign word    = cfg.len8 ? sh_q : {1'b0, sh_q[DW-1:1]};
    assign done    = run && (st_q == RX_STOP) && bit_end;

    assign perr_set = done && (cfg.par == PAR_ODD || cfg.par == PAR_EVEN)
                      && (par_q != par_bit(cfg.par, word));
    assign ferr_set = done && !rx_s;
    assign oerr_set = done && valid && !ack;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (!rx_s) st_d = RX_START;
            RX_START: if (mid_end) st_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bit_q == nbits - 1'b1)
                          st_d = (cfg.par == PAR_NONE) ? RX_STOP : RX_PAR;
            RX_PAR:   if (bit_end) st_d = RX_STOP;
            RX_STOP:  if (bit_end) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st_q <= RX_IDLE;
        else if (!run) st_q <= RX_IDLE;
        else           st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11; cnt_q <= '0; bit_q <= '0; sh_q <= '0; par_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            if (!run || st_q == RX_IDLE) begin
                cnt_q <= '0; bit_q <= '0;
            end else if (tick) begin
                if (mid_end && st_q == RX_START) begin
                    cnt_q <= '0;
                end else if (bit_end) begin
                    cnt_q <= '0;
                    if (st_q == RX_DATA) begin
                        sh_q  <= {rx_s, sh_q[DW-1:1]};
                        bit_q <= bit_q + 1'b1;
                    end
                    if (st_q == RX_PAR) par_q <= rx_s;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0; valid <= 1'b0; perr <= 1'b0; ferr <= 1'b0; oerr <= 1'b0; irq <= 1'b0;
        end else if (!run) begin
            valid <= 1'b0; perr <= 1'b0; ferr <= 1'b0; oerr <= 1'b0; irq <= 1'b0;
        end else begin
            if (done) begin
                dout  <= word;
                valid <= 1'b1;
            end else if (ack) begin
                valid <= 1'b0;
            end
            perr <= perr_set | (perr & !rd);
            ferr <= ferr_set | (ferr & !rd);
            oerr <= oerr_set | (oerr & !rd);
            irq  <= perr_set | ferr_set | oerr_set;
        end
    end

    assert_zero_par_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg.par == PAR_ZERO) |-> !perr_set);
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> $past(valid));
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_fmt_pkg::*;
#(
    parameter int OS   = 16,
    parameter int DW   = 8,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_en,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_parity,
    input  logic          cfg_len8,
    input  logic          cfg_stop2,
    input  logic          baud_tick,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_load,
    output logic          tx_ready,
    output logic          txd,
    input  logic          rxd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ack,
    input  logic          stat_rd,
    output logic          err_parity,
    output logic          err_frame,
    output logic          err_overrun,
    output logic          err_irq
);
    frame_cfg_t cfg_q;
    logic       tx_run, rx_run;
    logic       cfg_open;

    assign cfg_open = !tx_en && !rx_en && !tx_run && !rx_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '{par: PAR_NONE, len8: 1'b1, stop2: 1'b0};
        else if (cfg_we && cfg_open)
            cfg_q <= '{par: par_mode_t'(cfg_parity), len8: cfg_len8, stop2: cfg_stop2};
    end

    uart_en_gate #(.HOLD(HOLD)) u_tx_gate (
        .clk(clk), .rst_n(rst_n), .pwr(pwr_en), .en(tx_en), .run(tx_run));
    uart_en_gate #(.HOLD(HOLD)) u_rx_gate (
        .clk(clk), .rst_n(rst_n), .pwr(pwr_en), .en(rx_en), .run(rx_run));

    uart_tx #(.OS(OS), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .tick(baud_tick), .cfg(cfg_q),
        .din(tx_data), .load(tx_load), .ready(tx_ready), .txd(txd));

    uart_rx #(.OS(OS), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(rx_run), .tick(baud_tick), .cfg(cfg_q),
        .rxd(rxd), .ack(rx_ack), .rd(stat_rd), .dout(rx_data), .valid(rx_valid),
        .perr(err_parity), .ferr(err_frame), .oerr(err_overrun), .irq(err_irq));

    assert_cfg_locked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(cfg_q));
endmodule

// File: tb/test_uart_xcvr.sv
module test_uart_xcvr;
    logic clk = 1'b0, rst_n = 1'b0;
    logic pwr_en = 0, tx_en = 0, rx_en = 0, cfg_we = 0, cfg_len8 = 1, cfg_stop2 = 0;
    logic [1:0] cfg_parity = 2'b00;
    logic baud_tick = 0, tx_load = 0, rx_ack = 0, stat_rd = 0;
    logic [7:0] tx_data = 8'h00;
    logic tx_ready, txd, rx_valid, err_parity, err_frame, err_overrun, err_irq;
    logic [7:0] rx_data;
    logic loop = 1'b0, rx_drv = 1'b1;
    logic rxd;
    int checks = 0, failures = 0, irq_cnt = 0, irq_wide = 0;
    logic irq_prev = 1'b0;

    assign rxd = loop ? txd : rx_drv;

    uart_xcvr i_uart_xcvr (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_we(cfg_we), .cfg_parity(cfg_parity), .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2),
        .baud_tick(baud_tick), .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
        .stat_rd(stat_rd), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .err_irq(err_irq));

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        baud_tick = ~baud_tick;
    end

    always @(negedge clk) begin
        if (err_irq) irq_cnt++;
        if (err_irq && irq_prev) irq_wide++;
        irq_prev = err_irq;
    end

    function automatic logic [7:0] msk(input logic [7:0] d, input logic l8);
        return l8 ? d : {1'b0, d[6:0]};
    endfunction

    function automatic logic exp_par(input logic [1:0] m, input logic [7:0] d);
        if (m == 2'b10) return ~^d;
        if (m == 2'b11) return ^d;
        return 1'b0;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] p, input logic l8, input logic s2);
        @(negedge clk);
        cfg_parity = p; cfg_len8 = l8; cfg_stop2 = s2; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic enable_both(input logic t, input logic r);
        @(negedge clk);
        pwr_en = 1; tx_en = t; rx_en = r;
        cyc(10);
    endtask

    task automatic pulse_ack();
        @(negedge clk); rx_ack = 1; @(negedge clk); rx_ack = 0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    endtask

    // drive one frame on rxd: start, data, optional parity (flip corrupts it), stop level
    task automatic rx_frame(input logic [7:0] d, input logic l8, input logic [1:0] p,
                            input logic flip, input logic stop_lvl, input int gap);
        logic [7:0] m;
        m = msk(d, l8);
        @(negedge clk); rx_drv = 0; cyc(31);
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin
            @(negedge clk); rx_drv = m[i]; cyc(31);
        end
        if (p != 2'b00) begin
            @(negedge clk); rx_drv = (p == 2'b01) ? flip : (exp_par(p, m) ^ flip); cyc(31);
        end
        @(negedge clk); rx_drv = stop_lvl; cyc(31);
        @(negedge clk); rx_drv = 1; cyc(gap);
    endtask

    // load a character and check txd at every bit midpoint, then the frame end
    task automatic tx_frame(input logic [7:0] d, input logic [1:0] p, input logic l8, input logic s2);
        logic [7:0] m;
        int w, tail;
        m = msk(d, l8);
        w = 0;
        while (tx_ready !== 1'b1 && w < 200) begin @(negedge clk); w++; end
        tx_data = d; tx_load = 1;
        @(negedge clk); tx_load = 0;
        w = 0;
        while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
        cyc(16);
        chk("R1 start bit low", txd, 0);
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin
            cyc(32);
            chk("R1 data bit LSB first", txd, m[i]);
        end
        if (p != 2'b00) begin
            cyc(32);
            chk("R2 parity bit", txd, exp_par(p, m));
        end
        cyc(32);
        chk("R3 first stop high", txd, 1);
        tail = 0;
        while (tx_ready !== 1'b1 && tail < 200) begin @(negedge clk); tail++; end
        checks++;
        if (tail < 16 + 32 * s2 - 3 || tail > 16 + 32 * s2 + 3) begin
            failures++;
            $display("FAIL R3 stop length actual=%0d expected=%0d", tail, 16 + 32 * s2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int irq0;
        logic [7:0] d;
        logic [1:0] p;
        logic l8, s2;
        void'($urandom(32'd2024));
        cyc(4);
        rst_n = 1;
        cyc(4);
        // R11: reset and powered-down state
        chk("R11 txd idle high", txd, 1);
        chk("R11 tx_ready low when off", tx_ready, 0);
        chk("R11 rx_valid clear", rx_valid, 0);
        chk("R11 flags clear", {err_parity, err_frame, err_overrun}, 0);
        @(negedge clk); pwr_en = 1; cyc(10);
        chk("R11 tx_ready low without tx_en", tx_ready, 0);
        @(negedge clk); tx_en = 1; cyc(10);
        chk("R11 tx_ready after enable", tx_ready, 1);
        @(negedge clk); pwr_en = 0; cyc(2);
        chk("R11 power off drops ready", tx_ready, 0);
        chk("R11 power off line high", txd, 1);

        // R13: format write while enabled is ignored (default 8 bits, no parity, 1 stop)
        enable_both(1, 0);
        set_cfg(2'b10, 0, 1);
        tx_frame(8'hFF, 2'b00, 1, 0);

        // random loopback frames in every format
        @(negedge clk); loop = 1;
        irq0 = irq_cnt;
        for (int it = 0; it < 40; it++) begin
            @(negedge clk); tx_en = 0; rx_en = 0; cyc(6);
            p = 2'($urandom); l8 = 1'($urandom); s2 = 1'($urandom); d = 8'($urandom);
            set_cfg(p, l8, s2);
            enable_both(1, 1);
            tx_frame(d, p, l8, s2);
            chk("R4 loopback valid", rx_valid, 1);
            chk("R4 loopback data", rx_data, msk(d, l8));
            chk("R6 no framing error with either stop setting", err_frame, 0);
            chk("R5 no parity error on clean frame", err_parity, 0);
            pulse_ack();
            chk("R4 ack clears valid", rx_valid, 0);
        end
        chk("R8 no interrupt without errors", irq_cnt, irq0);
        @(negedge clk); loop = 0; tx_en = 0; rx_en = 0; cyc(6);

        // R5: zero-parity mode never flags a one in the parity slot
        set_cfg(2'b01, 1, 0);
        enable_both(0, 1);
        irq0 = irq_cnt;
        rx_frame(8'hA5, 1, 2'b01, 1, 1, 40);
        chk("R5 zero mode data", rx_data, 8'hA5);
        chk("R5 zero mode no parity flag", err_parity, 0);
        chk("R5 zero mode no interrupt", irq_cnt, irq0);
        pulse_ack();

        // R5/R8: odd parity mismatch, 7-bit character
        @(negedge clk); rx_en = 0; cyc(6);
        set_cfg(2'b10, 0, 0);
        enable_both(0, 1);
        irq0 = irq_cnt;
        rx_frame(8'h3C, 0, 2'b10, 1, 1, 40);
        chk("R5 odd mismatch flagged", err_parity, 1);
        chk("R4 seven-bit data", rx_data, 8'h3C);
        chk("R8 one interrupt pulse", irq_cnt, irq0 + 1);
        pulse_rd();
        chk("R8 status read clears flag", err_parity, 0);
        pulse_ack();

        // R6: low stop bit gives framing error (even parity, correct)
        @(negedge clk); rx_en = 0; cyc(6);
        set_cfg(2'b11, 1, 1);
        enable_both(0, 1);
        rx_frame(8'h81, 1, 2'b11, 0, 0, 40);
        chk("R6 framing error", err_frame, 1);
        chk("R5 even parity correct", err_parity, 0);
        pulse_rd(); pulse_ack();

        // R6/R7: back-to-back frames with one stop each and no ack in between
        irq0 = irq_cnt;
        rx_frame(8'h12, 1, 2'b11, 0, 1, 0);
        rx_frame(8'h34, 1, 2'b11, 0, 1, 40);
        chk("R7 overrun flagged", err_overrun, 1);
        chk("R7 newer data kept", rx_data, 8'h34);
        chk("R6 single stop accepted", err_frame, 0);
        chk("R8 overrun interrupt", irq_cnt, irq0 + 1);
        pulse_rd(); pulse_ack();

        // R9: short low glitch is rejected
        @(negedge clk); rx_drv = 0; cyc(8);
        @(negedge clk); rx_drv = 1; cyc(400);
        chk("R9 glitch gives no character", rx_valid, 0);
        chk("R9 glitch gives no framing error", err_frame, 0);

        // R11: disabling the receiver clears its held character
        rx_frame(8'h5A, 1, 2'b11, 0, 1, 40);
        chk("R11 character held", rx_valid, 1);
        @(negedge clk); rx_en = 0; cyc(6);
        chk("R11 disable clears valid", rx_valid, 0);

        // R10: enable while the line is already low
        set_cfg(2'b00, 1, 0);
        cyc(4);
        @(negedge clk); rx_drv = 0; rx_en = 1; cyc(31);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_drv = 1'(8'hC6 >> i); cyc(31);
        end
        @(negedge clk); rx_drv = 1; cyc(60);
        chk("R10 start taken on enable", rx_valid, 1);
        chk("R10 data after enable", rx_data, 8'hC6);
        pulse_ack();

        // R12: one-cycle enable drop aborts a frame in progress
        @(negedge clk); tx_en = 1; cyc(10);
        tx_data = 8'h00; tx_load = 1;
        @(negedge clk); tx_load = 0;
        cyc(48);
        chk("R12 frame in progress", txd, 0);
        @(negedge clk); tx_en = 0;
        @(negedge clk); tx_en = 1;
        cyc(3);
        chk("R12 held in reset after drop", tx_ready, 0);
        cyc(9);
        chk("R12 line released", txd, 1);
        chk("R12 reinitialised to ready", tx_ready, 1);
        chk("R8 interrupts single-cycle", irq_wide, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule